// File: doc/BRIEF.md
# Single-Cycle RV32I Processor Core with Exit Halt

This block is a processor core for the 32-bit base integer instruction set. Every clock cycle it completes one whole instruction: fetch, decode, operand read, ALU work, data memory access and register write-back. It holds the program counter, a 32-entry register file with two read ports and one write port, an immediate generator, a branch comparator and the main control decoder. It drives an instruction fetch port and a byte-addressable data port. Both memories answer reads with no wait state. The data port is one word wide, with one write enable per byte lane.

Programs end with an environment call. If register x17 holds the exit code 10 when the call executes, the core raises a sticky halt flag and then stops all architectural activity. If x17 holds any other value, the call retires as a plain no-op. Encodings outside the base integer set, such as multiply and divide, also retire with no effect.

Top module: `rvc_core`

## Requirements
- R1: Reset sets the program counter (`imem_addr`) to 0x0. After reset is released, every clock edge retires one instruction, and a non-control instruction advances the program counter by 4.
- R2: Register-register ADD, SUB, SLL, SLT, SLTU, XOR, SRL, SRA, OR and AND, and their immediate forms, write the RV32I result to rd on the edge that ends the instruction. Shifts use the low 5 bits of the second operand.
- R3: Reads of register x0 return zero, and a write to x0 is discarded.
- R4: LUI writes the 20-bit immediate into bits 31:12 of rd and clears bits 11:0. AUIPC writes the instruction's own address plus that upper immediate.
- R5: LB, LH, LW, LBU and LHU read the word at the effective address with its low two bits cleared. They take the byte or halfword starting at byte lane address[1:0], where lane i is bits 8i+7:8i, and sign-extend it (LB, LH) or zero-extend it (LBU, LHU).
- R6: SB, SH and SW drive `dmem_we` high and replicate the stored byte or halfword across `dmem_wdata`. `dmem_be` bit i enables lane i: SB sets only bit address[1:0], SH sets bits 1:0 or 3:2 according to address[1], and SW sets all four bits. Bytes outside the enabled lanes are unchanged.
- R7: BEQ, BNE, BLT, BGE, BLTU and BGEU compare rs1 with rs2. A taken branch moves the program counter to its own address plus the sign-extended B-type offset; a branch that is not taken moves it on by 4.
- R8: JAL writes PC+4 to rd and jumps to PC plus the J-type offset. JALR writes PC+4 to rd and jumps to rs1 plus the I-type immediate with bit 0 cleared.
- R9: An ECALL (0x00000073) that executes while x17 equals 10 sets `halted` at the edge that ends it. The program counter then stays at the ECALL's address. Reset clears `halted`.
- R10: An ECALL that executes while x17 holds any other value writes no register, raises no halt and advances the program counter by 4.
- R11: Once `halted` is high it stays high until reset. While it is high, the program counter does not change, `dmem_we` stays low and the register file takes no writes.
- R12: An OP-class encoding whose funct7 is neither 0000000 nor the 0100000 form of SUB or SRA (for example, multiply and divide with funct7 0000001) writes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the current instruction (the program counter) |
| imem_data | input | 32 | Instruction word at imem_addr, returned combinationally |
| dmem_addr | output | 32 | Effective byte address of a load or store |
| dmem_rdata | input | 32 | Word containing dmem_addr, returned combinationally |
| dmem_wdata | output | 32 | Store data, replicated across the byte lanes |
| dmem_be | output | 4 | Per-lane write enables; bit i enables bits 8i+7:8i |
| dmem_we | output | 1 | Store strobe, taken by the memory on the rising edge |
| halted | output | 1 | Sticky flag set by an ECALL that requests program exit |

## Verification
A register result or a store lands on the same rising edge that ends its instruction, and `halted` rises on the edge that ends the exit ECALL. The bench therefore counts edges from reset release: with the ECALL as the n-th instruction executed, `halted` is due at the falling edge after n edges. All program counter and flag samples are taken at falling edges, halfway between the rising edges that update them. Register and store results are read from the bench's data memory only after the halt, through store instructions that the test programs place before the exit call. The sweeps cover every ALU operation and every branch condition against a set of sign-boundary operands, with the expected values worked out arithmetically in the bench.

// File: rtl/rvc_pkg.sv
package rvc_pkg;

  localparam int XLEN   = 32;
  localparam int ILEN   = 32;
  localparam int NBYTE  = XLEN / 8;
  localparam int LANE_W = $clog2(NBYTE);
  localparam int SHW    = $clog2(XLEN);

  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_SYSTEM = 7'b1110011;

  localparam logic [ILEN-1:0] INSN_ECALL = 32'h0000_0073;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
    ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR, ALU_AND
  } alu_op_e;

  typedef enum logic [1:0] {
    WB_ALU, WB_MEM, WB_PC4
  } wb_sel_e;

  typedef struct packed {
    logic            reg_we;
    logic            a_is_pc;
    logic            a_is_zero;
    logic            b_is_imm;
    alu_op_e         alu_op;
    wb_sel_e         wb_sel;
    logic            is_load;
    logic            is_store;
    logic            is_branch;
    logic            is_jal;
    logic            is_jalr;
    logic            is_ecall;
    logic [2:0]      funct3;
    logic [XLEN-1:0] imm;
  } ctrl_t;

endpackage

// File: rtl/rvc_regfile.sv
module rvc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);

  logic [W-1:0] mem [NREG];

  // Array without reset so that it can map onto distributed or block RAM.
  always_ff @(posedge clk) begin
    if (we && (wa != '0)) begin
      mem[wa] <= wd;
    end
  end

  // R3: entry zero is never written and is masked on read.
  always_comb begin
    rd1 = (ra1 == '0) ? '0 : mem[ra1];
    rd2 = (ra2 == '0) ? '0 : mem[ra2];
  end

endmodule

// File: rtl/rvc_alu.sv
module rvc_alu
  import rvc_pkg::*;
#(
  parameter int W = XLEN,
  localparam int SW = $clog2(W)
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  logic [SW-1:0] sh;
  assign sh = b[SW-1:0];

  always_comb begin
    unique case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_SLL:  y = a << sh;
      ALU_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_SLTU: y = {{(W-1){1'b0}}, (a < b)};
      ALU_XOR:  y = a ^ b;
      ALU_SRL:  y = a >> sh;
      ALU_SRA:  y = $unsigned($signed(a) >>> sh);
      ALU_OR:   y = a | b;
      ALU_AND:  y = a & b;
      default:  y = '0;
    endcase
  end

endmodule

// File: rtl/rvc_branch.sv
module rvc_branch #(
  parameter int W = 32
) (
  input  logic [2:0]   funct3,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         taken
);

  logic eq, lts, ltu;
  assign eq  = (a == b);
  assign lts = ($signed(a) < $signed(b));
  assign ltu = (a < b);

  // R7: the condition code picks the comparison and its polarity.
  always_comb begin
    case (funct3)
      3'b000:  taken = eq;
      3'b001:  taken = !eq;
      3'b100:  taken = lts;
      3'b101:  taken = !lts;
      3'b110:  taken = ltu;
      3'b111:  taken = !ltu;
      default: taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/rvc_decode.sv
module rvc_decode
  import rvc_pkg::*;
(
  input  logic [ILEN-1:0] instr,
  output ctrl_t           ctrl,
  output logic [4:0]      rs1,
  output logic [4:0]      rs2,
  output logic [4:0]      rd
);

  logic [6:0] opc, f7;
  logic [2:0] f3;
  logic [XLEN-1:0] imm_i, imm_s, imm_b, imm_u, imm_j;

  assign opc = instr[6:0];
  assign f3  = instr[14:12];
  assign f7  = instr[31:25];
  assign rd  = instr[11:7];
  assign rs1 = instr[19:15];
  assign rs2 = instr[24:20];

  assign imm_i = {{20{instr[31]}}, instr[31:20]};
  assign imm_s = {{20{instr[31]}}, instr[31:25], instr[11:7]};
  assign imm_b = {{19{instr[31]}}, instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
  assign imm_u = {instr[31:12], 12'b0};
  assign imm_j = {{11{instr[31]}}, instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};

  always_comb begin
    ctrl        = '0;
    ctrl.alu_op = ALU_ADD;
    ctrl.wb_sel = WB_ALU;
    ctrl.funct3 = f3;
    unique case (opc)
      // R4
      OPC_LUI: begin
        ctrl.reg_we = 1'b1; ctrl.a_is_zero = 1'b1; ctrl.b_is_imm = 1'b1; ctrl.imm = imm_u;
      end
      OPC_AUIPC: begin
        ctrl.reg_we = 1'b1; ctrl.a_is_pc = 1'b1; ctrl.b_is_imm = 1'b1; ctrl.imm = imm_u;
      end
      // R8
      OPC_JAL: begin
        ctrl.reg_we = 1'b1; ctrl.is_jal = 1'b1; ctrl.wb_sel = WB_PC4; ctrl.imm = imm_j;
      end
      OPC_JALR: if (f3 == 3'b000) begin
        ctrl.reg_we = 1'b1; ctrl.is_jalr = 1'b1; ctrl.b_is_imm = 1'b1;
        ctrl.wb_sel = WB_PC4; ctrl.imm = imm_i;
      end
      // R7
      OPC_BRANCH: if (f3[2:1] != 2'b01) begin
        ctrl.is_branch = 1'b1; ctrl.imm = imm_b;
      end
      // R5
      OPC_LOAD: if (f3 != 3'b011 && f3[2:1] != 2'b11) begin
        ctrl.reg_we = 1'b1; ctrl.is_load = 1'b1; ctrl.b_is_imm = 1'b1;
        ctrl.wb_sel = WB_MEM; ctrl.imm = imm_i;
      end
      // R6
      OPC_STORE: if (f3[2] == 1'b0 && f3 != 3'b011) begin
        ctrl.is_store = 1'b1; ctrl.b_is_imm = 1'b1; ctrl.imm = imm_s;
      end
      // R2
      OPC_OPIMM: begin
        ctrl.b_is_imm = 1'b1; ctrl.imm = imm_i; ctrl.reg_we = 1'b1;
        case (f3)
          3'b000: ctrl.alu_op = ALU_ADD;
          3'b010: ctrl.alu_op = ALU_SLT;
          3'b011: ctrl.alu_op = ALU_SLTU;
          3'b100: ctrl.alu_op = ALU_XOR;
          3'b110: ctrl.alu_op = ALU_OR;
          3'b111: ctrl.alu_op = ALU_AND;
          3'b001: begin
            ctrl.alu_op = ALU_SLL; ctrl.reg_we = (f7 == 7'b0000000);
          end
          default: begin
            ctrl.alu_op = (f7 == 7'b0100000) ? ALU_SRA : ALU_SRL;
            ctrl.reg_we = (f7 == 7'b0000000) || (f7 == 7'b0100000);
          end
        endcase
      end
      // R2, R12: unknown funct7 leaves reg_we low.
      OPC_OP: begin
        ctrl.reg_we = 1'b1;
        case ({f7, f3})
          10'b0000000_000: ctrl.alu_op = ALU_ADD;
          10'b0100000_000: ctrl.alu_op = ALU_SUB;
          10'b0000000_001: ctrl.alu_op = ALU_SLL;
          10'b0000000_010: ctrl.alu_op = ALU_SLT;
          10'b0000000_011: ctrl.alu_op = ALU_SLTU;
          10'b0000000_100: ctrl.alu_op = ALU_XOR;
          10'b0000000_101: ctrl.alu_op = ALU_SRL;
          10'b0100000_101: ctrl.alu_op = ALU_SRA;
          10'b0000000_110: ctrl.alu_op = ALU_OR;
          10'b0000000_111: ctrl.alu_op = ALU_AND;
          default:         ctrl.reg_we = 1'b0;
        endcase
      end
      // R9, R10
      OPC_SYSTEM: ctrl.is_ecall = (instr == INSN_ECALL);
      default: ;
    endcase
  end

endmodule

// File: rtl/rvc_core.sv
module rvc_core
  import rvc_pkg::*;
#(
  parameter int              NREG      = 32,
  parameter int              HALT_REG  = 17,
  parameter int              HALT_CODE = 10,
  parameter logic [XLEN-1:0] RESET_PC  = '0,
  localparam int             AW        = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [XLEN-1:0]  imem_addr,
  input  logic [ILEN-1:0]  imem_data,
  output logic [XLEN-1:0]  dmem_addr,
  input  logic [XLEN-1:0]  dmem_rdata,
  output logic [XLEN-1:0]  dmem_wdata,
  output logic [NBYTE-1:0] dmem_be,
  output logic             dmem_we,
  output logic             halted
);

  logic [XLEN-1:0] pc, pc_plus4, pc_target, pc_next;
  ctrl_t           ctrl;
  logic [4:0]      rs1_f, rs2_f, rd_f;
  logic [AW-1:0]   ra1;
  logic [XLEN-1:0] rd1, rd2, alu_a, alu_b, alu_y, ld_val, ld_shift, wb_val;
  logic            br_taken, halt_now, rf_we;
  logic [LANE_W-1:0] lane;

  rvc_decode u_dec (
    .instr(imem_data), .ctrl(ctrl), .rs1(rs1_f), .rs2(rs2_f), .rd(rd_f)
  );

  // The exit check borrows read port 1: ECALL steers it to the code register.
  assign ra1 = ctrl.is_ecall ? AW'(HALT_REG) : rs1_f[AW-1:0];

  rvc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk(clk), .we(rf_we), .wa(rd_f[AW-1:0]), .wd(wb_val),
    .ra1(ra1), .ra2(rs2_f[AW-1:0]), .rd1(rd1), .rd2(rd2)
  );

  assign alu_a = ctrl.a_is_zero ? '0 : (ctrl.a_is_pc ? pc : rd1);
  assign alu_b = ctrl.b_is_imm ? ctrl.imm : rd2;

  rvc_alu #(.W(XLEN)) u_alu (.op(ctrl.alu_op), .a(alu_a), .b(alu_b), .y(alu_y));

  rvc_branch #(.W(XLEN)) u_br (.funct3(ctrl.funct3), .a(rd1), .b(rd2), .taken(br_taken));

  // Next-PC selection
  assign pc_plus4  = pc + XLEN'(4);
  assign pc_target = pc + ctrl.imm;

  always_comb begin
    if (ctrl.is_jal)                       pc_next = pc_target;
    else if (ctrl.is_jalr)                 pc_next = {alu_y[XLEN-1:1], 1'b0};
    else if (ctrl.is_branch && br_taken)   pc_next = pc_target;
    else                                   pc_next = pc_plus4;
  end

  // Data port: lane steering for loads and stores
  assign lane      = alu_y[LANE_W-1:0];
  assign dmem_addr = alu_y;
  assign ld_shift  = dmem_rdata >> {lane, 3'b000};

  always_comb begin
    case (ctrl.funct3)
      3'b000:  ld_val = {{(XLEN-8){ld_shift[7]}}, ld_shift[7:0]};
      3'b001:  ld_val = {{(XLEN-16){ld_shift[15]}}, ld_shift[15:0]};
      3'b100:  ld_val = {{(XLEN-8){1'b0}}, ld_shift[7:0]};
      3'b101:  ld_val = {{(XLEN-16){1'b0}}, ld_shift[15:0]};
      default: ld_val = dmem_rdata;
    endcase
  end

  always_comb begin
    case (ctrl.funct3)
      3'b000: begin
        dmem_wdata = {NBYTE{rd2[7:0]}};
        dmem_be    = NBYTE'(1) << lane;
      end
      3'b001: begin
        dmem_wdata = {(NBYTE/2){rd2[15:0]}};
        dmem_be    = NBYTE'(3) << {lane[LANE_W-1:1], 1'b0};
      end
      default: begin
        dmem_wdata = rd2;
        dmem_be    = '1;
      end
    endcase
  end

  assign dmem_we = ctrl.is_store && !halted;

  always_comb begin
    case (ctrl.wb_sel)
      WB_MEM:  wb_val = ld_val;
      WB_PC4:  wb_val = pc_plus4;
      default: wb_val = alu_y;
    endcase
  end

  assign halt_now = ctrl.is_ecall && !halted && (rd1 == XLEN'(HALT_CODE));
  assign rf_we    = ctrl.reg_we && !halted;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= RESET_PC;
      halted <= 1'b0;
    end else begin
      if (halt_now)                pc <= pc;
      else if (!halted)            pc <= pc_next;
      if (halt_now)                halted <= 1'b1;
    end
  end

  assign imem_addr = pc;

  // R1
  reset_pc_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pc == RESET_PC));

  // R9
  halt_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted && ctrl.is_ecall && rd1 == XLEN'(HALT_CODE)) |=> (halted && pc == $past(pc)));

  // R10
  ecall_nop_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted && ctrl.is_ecall && rd1 != XLEN'(HALT_CODE)) |=> (!halted && pc == $past(pc) + XLEN'(4)));

  // R11
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  // R11
  halt_pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable(pc));

  // R11
  halt_no_store_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !dmem_we);

  // R6
  store_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> ($countones(dmem_be) == 1 || $countones(dmem_be) == 2 || $countones(dmem_be) == 4));

endmodule

// File: tb/rvc_core_tb.sv
module rvc_core_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_rdata, dmem_wdata;
  logic [3:0]  dmem_be;
  logic        dmem_we, halted;

  always #4 clk = ~clk;

  rvc_core u_dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_rdata(dmem_rdata), .dmem_wdata(dmem_wdata),
    .dmem_be(dmem_be), .dmem_we(dmem_we), .halted(halted)
  );

  logic [31:0] imem [0:255];
  logic [7:0]  dmem [0:1023];
  logic [9:0]  dbase;

  assign imem_data  = imem[imem_addr[9:2]];
  assign dbase      = {dmem_addr[9:2], 2'b00};
  assign dmem_rdata = {dmem[dbase+10'd3], dmem[dbase+10'd2], dmem[dbase+10'd1], dmem[dbase]};

  always @(posedge clk)
    if (dmem_we)
      for (int i = 0; i < 4; i++)
        if (dmem_be[i]) dmem[dbase + 10'(i)] <= dmem_wdata[8*i +: 8];

  int checks = 0, errors = 0, plen = 0, cyc = 0;
  localparam logic [31:0] NOP = 32'h0000_0013, ECALL = 32'h0000_0073;

  function automatic logic [31:0] enc_r(logic [6:0] f7, logic [4:0] rs2, rs1, logic [2:0] f3, logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, 7'b0110011};
  endfunction
  function automatic logic [31:0] enc_i(logic [11:0] imm, logic [4:0] rs1, logic [2:0] f3, logic [4:0] rd, logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] enc_s(logic [11:0] imm, logic [4:0] rs2, rs1, logic [2:0] f3);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] enc_b(logic [12:0] imm, logic [4:0] rs2, rs1, logic [2:0] f3);
    return {imm[12], imm[10:5], rs2, rs1, f3, imm[4:1], imm[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] enc_u(logic [19:0] imm, logic [4:0] rd, logic [6:0] op);
    return {imm, rd, op};
  endfunction
  function automatic logic [31:0] enc_j(logic [20:0] imm, logic [4:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, 7'b1101111};
  endfunction

  function automatic logic [31:0] addi(logic [4:0] rd, rs1, logic [11:0] imm);
    return enc_i(imm, rs1, 3'b000, rd, 7'b0010011);
  endfunction
  function automatic logic [31:0] sw(logic [4:0] rs2, logic [11:0] off);
    return enc_s(off, rs2, 5'd0, 3'b010);
  endfunction

  function automatic logic [31:0] mw(int a);
    return {dmem[a+3], dmem[a+2], dmem[a+1], dmem[a]};
  endfunction

  task automatic put(input logic [31:0] w);
    imem[plen] = w;
    plen++;
  endtask

  task automatic li(input logic [4:0] rd, input logic [31:0] v);
    logic [31:0] hi;
    hi = (v + 32'h800) >> 12;
    put(enc_u(hi[19:0], rd, 7'b0110111));
    put(addi(rd, rd, v[11:0]));
  endtask

  task automatic new_prog(input logic [7:0] fill);
    for (int i = 0; i < 256; i++) imem[i] = NOP;
    for (int i = 0; i < 1024; i++) dmem[i] = fill;
    plen = 0;
  endtask

  task automatic finish_prog();
    put(addi(5'd17, 5'd0, 12'd10));
    put(ECALL);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_prog();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    cyc = 0;
    while (!halted && cyc < 400) begin
      @(negedge clk);
      cyc++;
    end
    if (!halted) begin
      checks++;
      errors++;
      $display("FAIL R9 program did not halt: actual 0 expected 1");
    end
  endtask

  function automatic logic [31:0] alu_ref(int k, logic [31:0] a, logic [31:0] b);
    case (k)
      0: return a + b;
      1: return a - b;
      2: return a << b[4:0];
      3: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4: return (a < b) ? 32'd1 : 32'd0;
      5: return a ^ b;
      6: return a >> b[4:0];
      7: return $unsigned($signed(a) >>> b[4:0]);
      8: return a | b;
      default: return a & b;
    endcase
  endfunction

  function automatic logic br_ref(logic [2:0] f3, logic [31:0] a, logic [31:0] b);
    case (f3)
      3'b000: return a == b;
      3'b001: return a != b;
      3'b100: return $signed(a) < $signed(b);
      3'b101: return $signed(a) >= $signed(b);
      3'b110: return a < b;
      default: return a >= b;
    endcase
  endfunction

  logic [31:0] vals [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                            32'h8000_0000, 32'h5, 32'h1234_5678, 32'h1F};
  logic [6:0]  rf7 [10] = '{7'h00, 7'h20, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h20, 7'h00, 7'h00};
  logic [2:0]  rf3 [10] = '{3'd0, 3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd5, 3'd6, 3'd7};
  logic [11:0] imms [6] = '{12'h000, 12'h001, 12'hFFF, 12'h7FF, 12'h800, 12'h555};
  logic [4:0]  shamts [4] = '{5'd0, 5'd1, 5'd15, 5'd31};
  int          ik [6] = '{0, 3, 4, 5, 8, 9};
  logic [2:0]  bf3 [6] = '{3'd0, 3'd1, 3'd4, 3'd5, 3'd6, 3'd7};

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hidx;
    // R2 register-register sweep
    for (int k = 0; k < 10; k++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) begin
          new_prog(8'h00);
          li(5'd1, vals[i]);
          li(5'd2, vals[j]);
          put(enc_r(rf7[k], 5'd2, 5'd1, rf3[k], 5'd3));
          put(sw(5'd3, 12'd0));
          finish_prog();
          run_prog();
          chk("R2", $sformatf("reg op %0d a=%h b=%h", k, vals[i], vals[j]), mw(0), alu_ref(k, vals[i], vals[j]));
        end

    // R2 immediate forms
    for (int k = 0; k < 6; k++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 6; j++) begin
          new_prog(8'h00);
          li(5'd1, vals[i]);
          put(enc_i(imms[j], 5'd1, rf3[ik[k]], 5'd3, 7'b0010011));
          put(sw(5'd3, 12'd0));
          finish_prog();
          run_prog();
          chk("R2", $sformatf("imm op %0d a=%h imm=%h", ik[k], vals[i], imms[j]), mw(0),
              alu_ref(ik[k], vals[i], {{20{imms[j][11]}}, imms[j]}));
        end
    for (int k = 0; k < 3; k++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 4; j++) begin
          int op;
          op = (k == 0) ? 2 : ((k == 1) ? 6 : 7);
          new_prog(8'h00);
          li(5'd1, vals[i]);
          put(enc_i({rf7[op], shamts[j]}, 5'd1, rf3[op], 5'd3, 7'b0010011));
          put(sw(5'd3, 12'd0));
          finish_prog();
          run_prog();
          chk("R2", $sformatf("shift-imm op %0d a=%h sh=%0d", op, vals[i], shamts[j]), mw(0),
              alu_ref(op, vals[i], {27'd0, shamts[j]}));
        end

    // R3 x0 stays zero
    new_prog(8'hFF);
    put(addi(5'd0, 5'd0, 12'd123));
    put(sw(5'd0, 12'd0));
    put(addi(5'd6, 5'd0, 12'd77));
    put(enc_r(7'h00, 5'd6, 5'd6, 3'd0, 5'd0));
    put(enc_r(7'h00, 5'd6, 5'd0, 3'd0, 5'd7));
    put(sw(5'd7, 12'd4));
    finish_prog();
    run_prog();
    chk("R3", "x0 after addi", mw(0), 32'h0);
    chk("R3", "x0 + x6 after write to x0", mw(4), 32'd77);

    // R4 LUI and AUIPC
    new_prog(8'h00);
    put(enc_u(20'hABCDE, 5'd5, 7'b0110111));
    put(sw(5'd5, 12'd0));
    put(enc_u(20'h12345, 5'd6, 7'b0010111));
    put(sw(5'd6, 12'd4));
    put(enc_u(20'hFFFFF, 5'd7, 7'b0010111));
    put(sw(5'd7, 12'd8));
    finish_prog();
    run_prog();
    chk("R4", "lui", mw(0), 32'hABCDE000);
    chk("R4", "auipc at 8", mw(4), 32'h12345008);
    chk("R4", "auipc at 16 negative", mw(8), 32'hFFFFF010);

    // R5 loads from pattern 0x80F17F82 at 0x40
    begin
      logic [31:0] pat, e;
      int n;
      pat = 32'h80F1_7F82;
      new_prog(8'h00);
      for (int b = 0; b < 4; b++) dmem[64+b] = pat[8*b +: 8];
      n = 0;
      for (int off = 0; off < 4; off++) begin
        put(enc_i(12'(64 + off), 5'd0, 3'b000, 5'd3, 7'b0000011));
        put(sw(5'd3, 12'(256 + 4*n))); n++;
        put(enc_i(12'(64 + off), 5'd0, 3'b100, 5'd3, 7'b0000011));
        put(sw(5'd3, 12'(256 + 4*n))); n++;
      end
      for (int off = 0; off < 4; off += 2) begin
        put(enc_i(12'(64 + off), 5'd0, 3'b001, 5'd3, 7'b0000011));
        put(sw(5'd3, 12'(256 + 4*n))); n++;
        put(enc_i(12'(64 + off), 5'd0, 3'b101, 5'd3, 7'b0000011));
        put(sw(5'd3, 12'(256 + 4*n))); n++;
      end
      put(enc_i(12'd64, 5'd0, 3'b010, 5'd3, 7'b0000011));
      put(sw(5'd3, 12'(256 + 4*n)));
      finish_prog();
      run_prog();
      n = 0;
      for (int off = 0; off < 4; off++) begin
        e = pat >> (8*off);
        chk("R5", $sformatf("LB lane %0d", off), mw(256 + 4*n), {{24{e[7]}}, e[7:0]}); n++;
        chk("R5", $sformatf("LBU lane %0d", off), mw(256 + 4*n), {24'd0, e[7:0]}); n++;
      end
      for (int off = 0; off < 4; off += 2) begin
        e = pat >> (8*off);
        chk("R5", $sformatf("LH lane %0d", off), mw(256 + 4*n), {{16{e[15]}}, e[15:0]}); n++;
        chk("R5", $sformatf("LHU lane %0d", off), mw(256 + 4*n), {16'd0, e[15:0]}); n++;
      end
      chk("R5", "LW", mw(256 + 4*n), pat);
    end

    // R6 stores into a 0xFF background
    new_prog(8'hFF);
    li(5'd1, 32'h1122_3344);
    for (int off = 0; off < 4; off++)
      put(enc_s(12'(128 + 5*off), 5'd1, 5'd0, 3'b000));
    put(enc_s(12'd144, 5'd1, 5'd0, 3'b001));
    put(enc_s(12'd150, 5'd1, 5'd0, 3'b001));
    put(enc_s(12'd152, 5'd1, 5'd0, 3'b010));
    finish_prog();
    run_prog();
    for (int off = 0; off < 4; off++) begin
      logic [31:0] e;
      e = 32'hFFFF_FFFF;
      e[8*off +: 8] = 8'h44;
      chk("R6", $sformatf("SB lane %0d", off), mw(128 + 4*off), e);
    end
    chk("R6", "SH low half", mw(144), 32'hFFFF_3344);
    chk("R6", "SH high half", mw(148), 32'h3344_FFFF);
    chk("R6", "SW", mw(152), 32'h1122_3344);
    chk("R6", "neighbour untouched", mw(156), 32'hFFFF_FFFF);

    // R7 branch conditions
    for (int c = 0; c < 6; c++)
      for (int i = 2; i < 7; i++)
        for (int j = 2; j < 7; j++) begin
          logic [31:0] a, b;
          a = (i == 5) ? 32'h0 : ((i == 6) ? 32'h1 : vals[i]);
          b = (j == 5) ? 32'h0 : ((j == 6) ? 32'h1 : vals[j]);
          new_prog(8'h00);
          li(5'd1, a);
          li(5'd2, b);
          put(addi(5'd3, 5'd0, 12'd0));
          put(enc_b(13'd8, 5'd2, 5'd1, bf3[c]));
          put(addi(5'd3, 5'd0, 12'd1));
          put(sw(5'd3, 12'd0));
          finish_prog();
          run_prog();
          chk("R7", $sformatf("branch f3=%0d a=%h b=%h", bf3[c], a, b), mw(0),
              br_ref(bf3[c], a, b) ? 32'd0 : 32'd1);
        end

    // R7 backward loop, R1 cycle count
    new_prog(8'h00);
    put(addi(5'd1, 5'd0, 12'd5));
    put(addi(5'd2, 5'd0, 12'd0));
    put(addi(5'd2, 5'd2, 12'd3));
    put(addi(5'd1, 5'd1, 12'hFFF));
    put(enc_b(13'h1FF8, 5'd0, 5'd1, 3'b001));
    put(sw(5'd2, 12'd0));
    finish_prog();
    run_prog();
    chk("R7", "backward loop sum", mw(0), 32'd15);
    chk("R1", "edges to halt for loop", 32'(cyc), 32'd20);

    // R8 JAL and JALR
    new_prog(8'h00);
    put(addi(5'd9, 5'd0, 12'd0));
    put(enc_j(21'd12, 5'd1));
    put(addi(5'd9, 5'd0, 12'd1));
    put(addi(5'd9, 5'd0, 12'd2));
    put(sw(5'd1, 12'd0));
    put(sw(5'd9, 12'd4));
    put(addi(5'd5, 5'd0, 12'd39));
    put(enc_i(12'd2, 5'd5, 3'b000, 5'd6, 7'b1100111));
    put(addi(5'd9, 5'd0, 12'd3));
    put(addi(5'd9, 5'd0, 12'd4));
    put(sw(5'd6, 12'd8));
    put(sw(5'd9, 12'd12));
    finish_prog();
    run_prog();
    chk("R8", "JAL link", mw(0), 32'd8);
    chk("R8", "JAL skipped path", mw(4), 32'd0);
    chk("R8", "JALR link", mw(8), 32'd32);
    chk("R8", "JALR odd target cleared", mw(12), 32'd0);

    // R12 unsupported OP encodings write nothing
    new_prog(8'h00);
    put(addi(5'd1, 5'd0, 12'd6));
    put(addi(5'd2, 5'd0, 12'd7));
    put(addi(5'd3, 5'd0, 12'd55));
    put(enc_r(7'h01, 5'd2, 5'd1, 3'd0, 5'd3));
    put(enc_r(7'h01, 5'd2, 5'd1, 3'd4, 5'd3));
    put(enc_r(7'h20, 5'd2, 5'd1, 3'd4, 5'd3));
    put(sw(5'd3, 12'd0));
    finish_prog();
    run_prog();
    chk("R12", "rd after mul/div/bad funct7", mw(0), 32'd55);

    // R9, R10, R11 ECALL behaviour
    new_prog(8'hFF);
    put(addi(5'd17, 5'd0, 12'd9));
    put(ECALL);
    li(5'd17, 32'h0000_010A);
    put(ECALL);
    put(addi(5'd4, 5'd0, 12'd7));
    put(sw(5'd4, 12'd0));
    put(addi(5'd17, 5'd0, 12'd10));
    hidx = plen;
    put(ECALL);
    put(sw(5'd0, 12'd4));
    run_prog();
    chk("R10", "code after non-exit ECALLs ran", mw(0), 32'd7);
    chk("R9", "edges until halted", 32'(cyc), 32'(hidx + 1));
    chk("R9", "pc held at exit ECALL", imem_addr, 32'(4 * hidx));
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R11", "halted sticky", {31'd0, halted}, 32'd1);
      chk("R11", "pc frozen", imem_addr, 32'(4 * hidx));
      chk("R11", "no store strobe", {31'd0, dmem_we}, 32'd0);
    end
    chk("R11", "store after exit not done", mw(4), 32'hFFFF_FFFF);

    // R1 reset state and straight-line stepping, R9 reset clears halt
    new_prog(8'h00);
    for (int k = 0; k < 4; k++) put(NOP);
    put(addi(5'd17, 5'd0, 12'd10));
    hidx = plen;
    put(ECALL);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "pc in reset", imem_addr, 32'h0);
    chk("R9", "halted cleared by reset", {31'd0, halted}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 1; k <= hidx; k++) begin
      @(negedge clk);
      chk("R1", $sformatf("pc after %0d edges", k), imem_addr, 32'(4 * k));
      chk("R9", "not halted before exit", {31'd0, halted}, 32'd0);
    end
    @(negedge clk);
    chk("R9", "halted after exit ECALL", {31'd0, halted}, 32'd1);
    chk("R9", "pc at exit ECALL", imem_addr, 32'(4 * hidx));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule